// File: doc/BRIEF.md
# Slot-Gated Signal-Strength Measurement Sequencer

This block is the digital control unit for received-signal-strength measurement in a TDMA radio interface. It drives an external peak/hold detector and an external 6-bit A/D converter, and runs one measurement per time slot without any software request, but only in slots where the receiver is active.

When a slot begins with the receiver on, the detector is cleared for one cycle and then left to integrate for a fixed number of clock cycles. After that window the detector is switched to hold and the converter receives a one-cycle start pulse. The converted value is latched when the converter signals completion. The result register carries a valid flag, which the slot-level controller consumes by reading once per slot, and a stale flag, which marks a value that belongs to an earlier slot.

Top module: `rssi_seq`

## Requirements
- R1: After reset, pk_reset, pk_hold, adc_start and rssi_valid are 0, rssi_value is 0 and rssi_stale is 1.
- R2: A slot_start sampled with rx_active high drives pk_reset high for exactly the following cycle. pk_reset and pk_hold are never high together.
- R3: If the receiver stays on, adc_start is a one-cycle pulse that is high in the cycle that begins WIN_CYCLES+2 clock edges after the slot_start edge. pk_hold is high from WIN_CYCLES+1 edges after that edge, so it is already high when adc_start is issued.
- R4: pk_hold stays high while the conversion is outstanding and falls in the cycle after the result is captured.
- R5: When adc_done is high after the start pulse, adc_data is latched into rssi_value, rssi_valid is set and rssi_stale is cleared, all on the next edge. adc_done at any other time leaves rssi_value unchanged.
- R6: rd_strobe clears rssi_valid on the next edge and leaves rssi_value unchanged.
- R7: Every slot_start clears rssi_valid and sets rssi_stale. In a slot that starts with rx_active low, pk_reset, pk_hold and adc_start stay 0 and rssi_value is kept.
- R8: If rx_active falls before the integration window ends, the slot's measurement is aborted. No hold or start is issued and rssi_valid stays 0 for that slot.
- R9: At most one sample is captured per slot, and a further adc_done in the same slot is ignored. A slot_start during a measurement restarts the sequence with R3 timing measured from the new edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slot_start | input | 1 | One-cycle strobe at the start of each time slot |
| rx_active | input | 1 | Receiver enabled in the current slot |
| adc_done | input | 1 | Converter completion flag |
| adc_data | input | DATA_W | Converted strength from the A/D converter |
| rd_strobe | input | 1 | Controller reads the result register |
| pk_reset | output | 1 | Clears the peak/hold detector |
| pk_hold | output | 1 | Switches the detector to hold |
| adc_start | output | 1 | Start-conversion pulse |
| rssi_value | output | DATA_W | Latched strength result |
| rssi_valid | output | 1 | Result is fresh and has not been read |
| rssi_stale | output | 1 | Result does not belong to the current slot |

## Verification
Counting from the edge that samples slot_start, pk_reset is due one cycle later, pk_hold after WIN_CYCLES+1 edges and adc_start after WIN_CYCLES+2 edges. The captured value, the valid and stale flags and the release of hold are all due one edge after adc_done or rd_strobe. The bench drives inputs on falling edges and counts falling edges from the slot strobe. Each output is compared against the cycle index at every step, so an output that comes early or late fails, and so does one with the wrong value. Abort and ignore cases are checked by watching the outputs for the whole window in which a wrong pulse could appear.

// File: rtl/rssi_seq.sv
module rssi_seq #(
  parameter int DATA_W     = 6,
  parameter int WIN_CYCLES = 3000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_start,
  input  logic              rx_active,
  input  logic              adc_done,
  input  logic [DATA_W-1:0] adc_data,
  input  logic              rd_strobe,
  output logic              pk_reset,
  output logic              pk_hold,
  output logic              adc_start,
  output logic [DATA_W-1:0] rssi_value,
  output logic              rssi_valid,
  output logic              rssi_stale
);
  localparam int CNT_W = $clog2(WIN_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WIN_CYCLES - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_ARM, S_INTEG, S_HOLD, S_START, S_WAIT, S_DONE
  } state_t;

  state_t           state;
  logic [CNT_W-1:0] cnt;

  assign pk_reset  = (state == S_ARM);
  assign pk_hold   = (state == S_HOLD) || (state == S_START) || (state == S_WAIT);
  assign adc_start = (state == S_START);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      cnt        <= '0;
      rssi_value <= '0;
      rssi_valid <= 1'b0;
      rssi_stale <= 1'b1;
    end else if (slot_start) begin
      rssi_valid <= 1'b0;
      rssi_stale <= 1'b1;
      cnt        <= '0;
      state      <= rx_active ? S_ARM : S_IDLE;
    end else begin
      if (rd_strobe) rssi_valid <= 1'b0;
      case (state)
        S_ARM:   state <= rx_active ? S_INTEG : S_IDLE;
        S_INTEG: begin
          if (!rx_active)     state <= S_IDLE;
          else if (cnt == LAST) state <= S_HOLD;
          else                cnt <= cnt + 1'b1;
        end
        S_HOLD:  state <= S_START;
        S_START: state <= S_WAIT;
        S_WAIT:  if (adc_done) begin
          rssi_value <= adc_data;
          rssi_valid <= 1'b1;
          rssi_stale <= 1'b0;
          state      <= S_DONE;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rssi_seq_chk.sv
module rssi_seq_chk #(
  parameter int DATA_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              slot_start,
  input logic              rx_active,
  input logic              adc_done,
  input logic              rd_strobe,
  input logic              pk_reset,
  input logic              pk_hold,
  input logic              adc_start,
  input logic [DATA_W-1:0] rssi_value,
  input logic              rssi_valid
);
  assert_reset_hold_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(pk_reset && pk_hold));
  assert_start_under_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> pk_hold);
  assert_start_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> !adc_start);
  assert_valid_needs_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rssi_valid) |-> $past(adc_done));
  assert_value_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_done |=> $stable(rssi_value));
  assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !adc_done) |=> !rssi_valid);
  assert_slot_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    slot_start |=> !rssi_valid);
  assert_idle_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_start && !rx_active) |=> (!pk_reset && !pk_hold && !adc_start));
  assert_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pk_reset && !rx_active && !slot_start) |=> (!pk_hold && !adc_start));
endmodule

bind rssi_seq rssi_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .slot_start(slot_start), .rx_active(rx_active),
  .adc_done(adc_done), .rd_strobe(rd_strobe), .pk_reset(pk_reset),
  .pk_hold(pk_hold), .adc_start(adc_start), .rssi_value(rssi_value),
  .rssi_valid(rssi_valid)
);

// File: tb/tb_rssi_seq.sv
module tb_rssi_seq;
  localparam int DW  = 6;
  localparam int WIN = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic slot_start = 1'b0, rx_active = 1'b0, adc_done = 1'b0, rd_strobe = 1'b0;
  logic [DW-1:0] adc_data = '0;
  logic pk_reset, pk_hold, adc_start, rssi_valid, rssi_stale;
  logic [DW-1:0] rssi_value;
  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  rssi_seq #(.DATA_W(DW), .WIN_CYCLES(WIN)) dut (
    .clk(clk), .rst_n(rst_n), .slot_start(slot_start), .rx_active(rx_active),
    .adc_done(adc_done), .adc_data(adc_data), .rd_strobe(rd_strobe),
    .pk_reset(pk_reset), .pk_hold(pk_hold), .adc_start(adc_start),
    .rssi_value(rssi_value), .rssi_valid(rssi_valid), .rssi_stale(rssi_stale)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic slot_pulse(input logic rx);
    @(negedge clk);
    slot_start = 1'b1; rx_active = rx;
    @(negedge clk);
    slot_start = 1'b0;
  endtask

  task automatic watch_to_start();
    chk(pk_reset == 1'b1, "R2 pk_reset after slot", pk_reset, 1);
    for (int i = 1; i <= WIN + 2; i++) begin
      @(negedge clk);
      chk(pk_reset == 1'b0, "R2 pk_reset single", pk_reset, 0);
      chk(adc_start == (i == WIN + 2), "R3 adc_start timing", adc_start, int'(i == WIN + 2));
      chk(pk_hold == (i >= WIN + 1), "R3 pk_hold timing", pk_hold, int'(i >= WIN + 1));
    end
  endtask

  task automatic finish_conv(input logic [DW-1:0] d);
    @(negedge clk);
    chk(adc_start == 1'b0, "R3 adc_start one cycle", adc_start, 0);
    chk(pk_hold == 1'b1, "R4 hold while converting", pk_hold, 1);
    adc_data = d; adc_done = 1'b1;
    @(negedge clk);
    adc_done = 1'b0;
    chk(rssi_value == d, "R5 captured value", rssi_value, d);
    chk(rssi_valid == 1'b1, "R5 valid set", rssi_valid, 1);
    chk(rssi_stale == 1'b0, "R5 stale cleared", rssi_stale, 0);
    chk(pk_hold == 1'b0, "R4 hold released", pk_hold, 0);
  endtask

  task automatic t_reset();
    chk(pk_reset == 0 && pk_hold == 0 && adc_start == 0, "R1 controls idle",
        {pk_reset, pk_hold, adc_start}, 0);
    chk(rssi_valid == 0, "R1 valid", rssi_valid, 0);
    chk(rssi_value == 0, "R1 value", rssi_value, 0);
    chk(rssi_stale == 1, "R1 stale", rssi_stale, 1);
  endtask

  task automatic t_normal(input logic [DW-1:0] d);
    slot_pulse(1'b1);
    watch_to_start();
    finish_conv(d);
  endtask

  task automatic t_extra_done();
    @(negedge clk);
    adc_data = 6'h15; adc_done = 1'b1;
    @(negedge clk);
    adc_done = 1'b0;
    chk(rssi_value == 6'h2A, "R9 second done ignored", rssi_value, 6'h2A);
    chk(pk_hold == 0 && adc_start == 0, "R9 no second conversion", {pk_hold, adc_start}, 0);
  endtask

  task automatic t_read();
    @(negedge clk);
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
    chk(rssi_valid == 0, "R6 read clears valid", rssi_valid, 0);
    chk(rssi_value == 6'h2A, "R6 value kept", rssi_value, 6'h2A);
  endtask

  task automatic t_rx_off_slot();
    t_normal(6'h3F);
    slot_pulse(1'b0);
    chk(rssi_valid == 0, "R7 slot clears valid", rssi_valid, 0);
    chk(rssi_stale == 1, "R7 slot sets stale", rssi_stale, 1);
    for (int i = 0; i < WIN + 6; i++) begin
      chk(pk_reset == 0 && pk_hold == 0 && adc_start == 0, "R7 no activity",
          {pk_reset, pk_hold, adc_start}, 0);
      @(negedge clk);
    end
    chk(rssi_value == 6'h3F, "R7 value kept", rssi_value, 6'h3F);
  endtask

  task automatic t_abort();
    slot_pulse(1'b1);
    repeat (3) @(negedge clk);
    rx_active = 1'b0;
    for (int i = 0; i < WIN + 4; i++) begin
      @(negedge clk);
      chk(pk_hold == 0 && adc_start == 0, "R8 no hold or start", {pk_hold, adc_start}, 0);
    end
    adc_data = 6'h07; adc_done = 1'b1;
    @(negedge clk);
    adc_done = 1'b0;
    chk(rssi_valid == 0, "R8 no valid after abort", rssi_valid, 0);
    chk(rssi_value == 6'h3F, "R8 value kept", rssi_value, 6'h3F);
  endtask

  task automatic t_early_done();
    slot_pulse(1'b1);
    chk(pk_reset == 1, "R2 pk_reset", pk_reset, 1);
    repeat (4) @(negedge clk);
    adc_data = 6'h11; adc_done = 1'b1;
    @(negedge clk);
    adc_done = 1'b0;
    chk(rssi_value == 6'h3F && rssi_valid == 0, "R5 early done ignored", rssi_value, 6'h3F);
    slot_pulse(1'b1);
    watch_to_start();
    finish_conv(6'h01);
  endtask

  task automatic t_restart();
    slot_pulse(1'b1);
    repeat (5) @(negedge clk);
    slot_pulse(1'b1);
    watch_to_start();
    finish_conv(6'h20);
    chk(rssi_value == 6'h20, "R9 restart captured once", rssi_value, 6'h20);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_normal(6'h2A);
    t_extra_done();
    t_read();
    t_rx_off_slot();
    t_abort();
    t_early_done();
    t_restart();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule